// File: doc/BRIEF.md
# Watchdog Timer with Frozen Configuration

This block is a watchdog that counts either every system clock or every pulse of a slow RC clock enable. When the count reaches the selected tap, it raises a one-cycle reset request. Software holds the request off by pulsing a refresh strobe, which restarts the count from zero. While the chip is in STOP mode, counting is suspended.

The 3-bit mode word cannot be read back. It can be written once, and only inside a window of 60 system clocks. That window opens after power-on reset, after every watchdog timeout and after every STOP recovery. Once the window has closed, or once a write has been taken inside it, the configuration stays fixed until the window opens again.

A timeout puts the mode back to its default. A STOP recovery leaves the mode as it was, but it clears the count and reopens the window.

Top module: `wdt_locked_top`

## Requirements
- R1: During and right after reset, `wdt_rst_o` is low. The mode is the default: a tap of 256, counted on the system clock.
- R2: The counter advances on each enabled tick. On the tick that completes the tap count, the counter returns to zero, and `wdt_rst_o` is high for exactly one clock after that edge.
- R3: Mode word encoding:
  - bits [1:0] select the tap as 128 << sel (00=128, 01=256, 10=512, 11=1024).
  - bit 2 selects the count source: 0 counts every system clock, 1 counts only cycles with `rc_tick_i` high.
  - A written mode takes effect from the next clock.
- R4: A write (`cfg_we_i`) is accepted only on the first 60 clock edges after the window opens (ages 0 to 59). A write on edge 61 or later has no effect on the timeout.
- R5: Once a write has been accepted, any further write in the same window is ignored.
- R6: While `stop_i` is high, the counter holds its value and no reset request is raised.
- R7: `kick_i` clears the counter, so the next timeout comes a full tap count after the refresh edge.
- R8: A timeout restores the default mode and reopens the write window.
- R9: `stop_rcv_i` clears the counter and reopens the write window. It keeps the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rc_tick_i | input | 1 | Enable pulse from the slow RC clock, synchronous to clk |
| stop_i | input | 1 | High while the device is in STOP mode |
| stop_rcv_i | input | 1 | One-cycle pulse signalling a STOP-mode recovery |
| kick_i | input | 1 | Refresh strobe |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_wdata_i | input | 3 | Mode word: {source, tap select[1:0]} |
| wdt_rst_o | output | 1 | Watchdog reset request |

## Verification
With the system clock as source, the reset request rises on the clock after the edge that carries the N-th counted tick. A refresh or a STOP recovery sets the next timeout a full tap count after its own edge. A mode write changes the count rule only from the next edge, so the write edge itself is still counted under the old mode.

The bench measures each timeout as a number of clocks from a known starting edge, and compares that number with the value derived from these rules, including the 59/60 window boundary. In addition, a behavioural model predicts `wdt_rst_o` for every cycle. The bench samples on the falling edge, half a period after the register that drives the output.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;

  typedef struct packed {
    logic       rc_src;   // 1: count RC enable pulses, 0: count system clocks
    logic [1:0] tap_sel;  // tap = base << tap_sel
  } wdt_mode_t;

  localparam wdt_mode_t MODE_DEFAULT = '{rc_src: 1'b0, tap_sel: 2'd1};

  // Number of ticks that make up one timeout for a given tap selection.
  function automatic int unsigned tap_span(input int unsigned base_log,
                                           input logic [1:0]  sel);
    return 32'd1 << (base_log + 32'(sel));
  endfunction

endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_lock_pkg::*;
#(
  parameter int unsigned WIN_CYC = 60
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reopen_i,   // timeout or stop recovery
  input  logic      restore_i,  // timeout: go back to default mode
  input  logic      we_i,
  input  wdt_mode_t wdata_i,
  output wdt_mode_t mode_o,
  output logic      win_open_o,
  output logic      commit_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);

  logic [WIN_W-1:0] age_q;
  logic             written_q;
  wdt_mode_t        mode_q;

  assign win_open_o = (age_q < WIN_W'(WIN_CYC)) && !written_q;
  assign commit_o   = we_i && win_open_o && !reopen_i;
  assign mode_o     = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q     <= '0;
      written_q <= 1'b0;
      mode_q    <= MODE_DEFAULT;
    end else if (reopen_i) begin
      age_q     <= '0;
      written_q <= 1'b0;
      if (restore_i) mode_q <= MODE_DEFAULT;
    end else begin
      if (commit_o) begin
        mode_q    <= wdata_i;
        written_q <= 1'b1;
      end
      if (age_q < WIN_W'(WIN_CYC)) age_q <= age_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_lock_pkg::*;
(
  input  wdt_mode_t mode_i,
  input  logic      rc_tick_i,
  input  logic      stop_i,
  output logic      tick_o
);
  logic src_tick;

  assign src_tick = mode_i.rc_src ? rc_tick_i : 1'b1;
  assign tick_o   = src_tick && !stop_i;

endmodule

// File: rtl/wdt_chain.sv
module wdt_chain
  import wdt_lock_pkg::*;
#(
  parameter int unsigned BASE_LOG = 7,
  parameter int unsigned CNT_W    = BASE_LOG + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [1:0]       tap_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             req_q;

  assign last_val = CNT_W'(tap_span(BASE_LOG, tap_sel_i) - 32'd1);
  assign hit_o    = tick_i && !clear_i && (cnt_q == last_val);
  assign cnt_o    = cnt_q;
  assign req_o    = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= hit_o;
      if (clear_i || hit_o) cnt_q <= '0;
      else if (tick_i)      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_locked_top.sv
module wdt_locked_top
  import wdt_lock_pkg::*;
#(
  parameter int unsigned BASE_LOG = 7,
  parameter int unsigned WIN_CYC  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rc_tick_i,
  input  logic       stop_i,
  input  logic       stop_rcv_i,
  input  logic       kick_i,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_wdata_i,
  output logic       wdt_rst_o
);
  localparam int unsigned CNT_W = BASE_LOG + 3;

  wdt_mode_t        mode_q;
  wdt_mode_t        wr_mode;
  logic             win_open;
  logic             commit;
  logic             tick_en;
  logic             hit;
  logic             reopen;
  logic [CNT_W-1:0] cnt;

  assign wr_mode = wdt_mode_t'(cfg_wdata_i);
  assign reopen  = hit || stop_rcv_i;

  wdt_cfg_lock #(.WIN_CYC(WIN_CYC)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .reopen_i  (reopen),
    .restore_i (hit),
    .we_i      (cfg_we_i),
    .wdata_i   (wr_mode),
    .mode_o    (mode_q),
    .win_open_o(win_open),
    .commit_o  (commit)
  );

  wdt_tick_sel u_tick (
    .mode_i   (mode_q),
    .rc_tick_i(rc_tick_i),
    .stop_i   (stop_i),
    .tick_o   (tick_en)
  );

  wdt_chain #(.BASE_LOG(BASE_LOG), .CNT_W(CNT_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (kick_i || stop_rcv_i),
    .tick_i   (tick_en),
    .tap_sel_i(mode_q.tap_sel),
    .cnt_o    (cnt),
    .hit_o    (hit),
    .req_o    (wdt_rst_o)
  );

endmodule

// File: rtl/wdt_locked_chk.sv
module wdt_locked_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             kick_i,
  input logic             stop_rcv_i,
  input logic             wdt_rst_o,
  input logic             win_open,
  input logic             commit,
  input logic             hit,
  input logic             tick_en,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       mode
);
  // R6
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !tick_en);

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !kick_i && !stop_rcv_i) |=> $stable(cnt));

  // R7
  refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt == '0));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> $past(hit));

  // R8
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> win_open);

  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !hit && !stop_rcv_i) |=> $stable(mode));

  // R5
  once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !hit) |=> !win_open);

  // R9
  keep_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rcv_i |=> ($stable(mode) && win_open && cnt == '0));

endmodule

bind wdt_locked_top wdt_locked_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_i    (stop_i),
  .kick_i    (kick_i),
  .stop_rcv_i(stop_rcv_i),
  .wdt_rst_o (wdt_rst_o),
  .win_open  (win_open),
  .commit    (commit),
  .hit       (hit),
  .tick_en   (tick_en),
  .cnt       (cnt),
  .mode      (mode_q)
);

// File: tb/sim_wdt_locked_top.sv
`timescale 1ns/1ps
module sim_wdt_locked_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rc_tick = 1'b0;
  logic       stop = 1'b0;
  logic       srcv = 1'b0;
  logic       kick = 1'b0;
  logic       we = 1'b0;
  logic [2:0] wd = 3'b000;
  logic       wdt_rst;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wdt_locked_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .rc_tick_i  (rc_tick),
    .stop_i     (stop),
    .stop_rcv_i (srcv),
    .kick_i     (kick),
    .cfg_we_i   (we),
    .cfg_wdata_i(wd),
    .wdt_rst_o  (wdt_rst)
  );

  // Behavioural reference model
  int m_sel, m_src, m_age, m_wr, m_cnt, m_lim;
  bit m_req, m_tick, m_hit, m_open;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 1; m_src = 0; m_age = 0; m_wr = 0; m_cnt = 0; m_req = 0;
    end else begin
      m_lim  = 128 * (2 ** m_sel);
      m_tick = !stop && (m_src == 1 ? rc_tick : 1'b1);
      m_hit  = m_tick && !kick && !srcv && (m_cnt == m_lim - 1);
      m_open = (m_age < 60) && (m_wr == 0);
      m_req  = m_hit;
      if (kick || srcv || m_hit) m_cnt = 0;
      else if (m_tick) m_cnt = m_cnt + 1;
      if (m_hit) begin
        m_sel = 1; m_src = 0; m_age = 0; m_wr = 0;
      end else if (srcv) begin
        m_age = 0; m_wr = 0;
      end else begin
        if (we && m_open) begin
          m_sel = int'(wd[1:0]); m_src = int'(wd[2]); m_wr = 1;
        end
        if (m_age < 60) m_age = m_age + 1;
      end
    end
  end

  // Per-cycle comparison and watchdog
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (wdt_rst !== m_req) begin
        errors++;
        $display("FAIL %s cycle %0d: wdt_rst_o=%0b expected %0b",
                 cur_req, cycles, wdt_rst, m_req);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Count clocks from the current falling edge until wdt_rst_o is seen.
  task automatic measure(input bit wr_first, input logic [2:0] wr_val,
                         input int rc_per, output int n);
    n = 0;
    do begin
      if (n == 0) begin we = wr_first; wd = wr_val; end
      else we = 1'b0;
      rc_tick = (rc_per > 1) ? ((n % rc_per) == rc_per - 1) : 1'b0;
      @(negedge clk);
      n++;
    end while (!wdt_rst && n < 5000);
    we = 1'b0;
    rc_tick = 1'b0;
  endtask

  task automatic quiet(input int len, input string req);
    int seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 reset output", int'(wdt_rst), 0);
    rst_n = 1'b1;

    // R1/R2: default tap 256 on system clock
    cur_req = "R2";
    measure(1'b0, 3'b000, 1, n);
    check("R1 R2 default tap", n, 256);

    // R3/R5: write tap 128, then a second write of 512 is ignored
    cur_req = "R5";
    we = 1'b1; wd = 3'b000;
    @(negedge clk);
    measure(1'b1, 3'b010, 1, n);
    check("R3 R5 tap 128 write once", n + 1, 128);

    // R4: write on edge 61 after the window opened is ignored
    cur_req = "R4";
    repeat (60) @(negedge clk);
    measure(1'b1, 3'b010, 1, n);
    check("R4 late write ignored", n + 60, 256);

    // R4: write on the 60th edge (age 59) is accepted, tap 512
    repeat (59) @(negedge clk);
    measure(1'b1, 3'b010, 1, n);
    check("R4 R3 last window edge tap 512", n + 59, 512);

    // R3: tap 1024
    cur_req = "R3";
    measure(1'b1, 3'b011, 1, n);
    check("R3 tap 1024", n, 1024);

    // R3: RC source, tap 128, ticks every 4th clock.
    // Write edge counts once on the system clock, then 127 RC ticks.
    measure(1'b1, 3'b100, 4, n);
    check("R3 rc source", n, 508);

    // R6/R8: stop halts counting; default mode restored after timeout
    cur_req = "R6";
    stop = 1'b1;
    quiet(500, "R6 no timeout in stop");
    stop = 1'b0;
    measure(1'b0, 3'b000, 1, n);
    check("R6 R8 resumes with default tap", n, 256 + 1 - 1);

    // R7: refresh keeps the timer quiet and restarts the count
    cur_req = "R7";
    for (int k = 0; k < 5; k++) begin
      quiet(200, "R7 refreshed, no timeout");
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
    end
    measure(1'b0, 3'b000, 1, n);
    check("R7 full span after refresh", n, 256);

    // R9: stop recovery keeps mode (128) and clears the count
    cur_req = "R9";
    we = 1'b1; wd = 3'b000;
    @(negedge clk);
    we = 1'b0;
    repeat (99) @(negedge clk);
    srcv = 1'b1;
    @(negedge clk);
    srcv = 1'b0;
    measure(1'b0, 3'b000, 1, n);
    check("R9 mode kept after recovery", n, 128);

    // R9: stop recovery reopens the window for a new write (512)
    we = 1'b1; wd = 3'b000;
    @(negedge clk);
    we = 1'b0;
    repeat (99) @(negedge clk);
    srcv = 1'b1;
    @(negedge clk);
    srcv = 1'b0;
    measure(1'b1, 3'b010, 1, n);
    check("R9 window reopened", n, 512);

    // R8: after that timeout the default tap is back
    cur_req = "R8";
    measure(1'b0, 3'b000, 1, n);
    check("R8 default after timeout", n, 256);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule